// File: doc/BRIEF.md
# Procedure Migration Handshake Controller

This block decides, for every core of a cluster whose cores share their first-level memories, whether a procedure the core is about to call runs on that core or moves to another core. Each core presents an 8-bit unsigned vulnerability score together with its call. If the score is less than or equal to a programmable threshold, the call goes ahead locally. Otherwise the block posts an entry for the caller in a shared migration table and broadcasts a request. It then starts a programmable timer and waits for a completion acknowledgement or for the timer to run out. Because the memories are shared, no data moves: the block only carries the handshake.

On the callee side, an idle core whose own score passes the threshold claims the pending entry. The entry becomes running and the core is told to start. When that core reports completion, the entry becomes done and an acknowledgement goes to the caller, which then returns. If the timer runs out first, the caller runs the procedure itself and the entry is cleared. A completion for a cleared entry is then dropped.

Each caller has a state machine with two states. In CLR_IDLE, a call whose score is within the threshold leaves by the transition "run local". A call whose score is above it takes the transition "post", which goes to CLR_WAIT. From CLR_WAIT there are two transitions back to CLR_IDLE: "return", on acknowledgement with the entry done, and "expire", on timeout. Each callee has a state machine with two states: CLE_IDLE goes to CLE_EXEC by "grant", and CLE_EXEC goes back to CLE_IDLE by "finish". A table entry moves through the states ST_IDLE, ST_PEND, ST_RUN and ST_DONE, in that order.

Top module: `hop_dispatch_ctrl`

## Requirements
- R1: While reset is held and at the first sample after reset, every output is zero and the migration table holds no entry.
- R2: A call sampled while its core is idle, with score less than or equal to cfg_thresh, raises that core's run_local bit for one cycle in the cycle after the call and posts nothing.
- R3: A call sampled while its core is idle, with score above cfg_thresh, raises that core's req_vec bit for one cycle in the cycle after the call. It also posts a pending entry for the core and loads the timer with cfg_timeout.
- R4: Each cycle at most one claim is granted. The claimed entry is the lowest-index pending entry and the claiming core is the lowest-index eligible core. One cycle later exec_start is one-hot on the claimer, exec_proc carries the posted procedure id and exec_caller carries the caller index. The claimer is never the caller.
- R5: A core whose own score is above cfg_thresh never claims. The claim passes to the next eligible core.
- R6: exec_done from a core that is executing a running entry marks that entry done, and in the next cycle raises ack_vec at the caller's bit for one cycle.
- R7: A waiting caller that sees its acknowledgement with its entry done raises hop_return for one cycle in the next cycle, clears the entry and becomes idle.
- R8: With no completion, a caller expires after cfg_timeout+1 cycles in the waiting state. It then raises run_local, clears the entry, and any later completion by the former claimer yields no ack_vec bit.
- R9: When a completion arrives in the same cycle as the caller's timer reaches zero, the completion wins: no run_local, then ack_vec and hop_return follow as in R6 and R7.
- R10: A core that is waiting as a caller, executing as a callee, or presenting a call in the current cycle is not eligible to claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_thresh | input | SCORE_W | Vulnerability threshold |
| cfg_timeout | input | TMO_W | Timer load value for a posted call |
| call_valid | input | N_CORES | Per-core call request, one cycle |
| call_proc | input | N_CORES*PROC_W | Per-core procedure id, core i at bits i*PROC_W |
| core_vuln | input | N_CORES*SCORE_W | Per-core vulnerability score, core i at bits i*SCORE_W |
| exec_done | input | N_CORES | Per-core completion of a migrated procedure |
| run_local | output | N_CORES | Pulse: run the call on the calling core |
| hop_return | output | N_CORES | Pulse: migrated call finished, caller returns |
| req_vec | output | N_CORES | Pulse: broadcast request from the posting caller |
| ack_vec | output | N_CORES | Pulse: broadcast acknowledgement to the caller |
| exec_start | output | N_CORES | Pulse: one-hot start to the claiming core |
| exec_proc | output | PROC_W | Procedure id with exec_start, zero otherwise |
| exec_caller | output | CID_W | Caller index with exec_start, zero otherwise |

## Verification
The same-cycle case that matters is a callee's completion landing in the cycle in which the caller's timer reaches zero. The bench provokes it by loading a short timeout and timing exec_done to the counted expiry cycle. It then checks that run_local stays low and that ack_vec and, one cycle later, hop_return arrive. The other coincidence is two callers posting in one cycle. This is judged by the claims coming out one per cycle, in index order, to different callees. A behavioural model compared on every clock covers both cases in a random phase as well.

// File: rtl/hop_pkg.sv
package hop_pkg;

    // Status of one migration table entry
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } hop_stat_e;

    // Caller-side sequencing
    typedef enum logic {
        CLR_IDLE = 1'b0,
        CLR_WAIT = 1'b1
    } caller_st_e;

    // Callee-side sequencing
    typedef enum logic {
        CLE_IDLE = 1'b0,
        CLE_EXEC = 1'b1
    } callee_st_e;

endpackage

// File: rtl/hop_caller_fsm.sv
module hop_caller_fsm
    import hop_pkg::*;
#(
    parameter int SCORE_W = 8,
    parameter int TMO_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               call_valid,
    input  logic [SCORE_W-1:0] score,
    input  logic [SCORE_W-1:0] thresh,
    input  logic [TMO_W-1:0]   timeout,
    input  hop_stat_e          ent_status,
    input  logic               ack_in,
    input  logic               done_hit,
    output logic               post_en,
    output logic               clear_en,
    output logic               busy,
    output logic               tmo_now,
    output logic               run_local,
    output logic               hop_return,
    output logic               req_pulse
);

    caller_st_e       st_q, st_d;
    logic [TMO_W-1:0] tmr_q;
    logic             local_go;
    logic             back;

    // Transition conditions
    always_comb begin
        local_go = 1'b0;
        post_en  = 1'b0;
        back     = 1'b0;
        tmo_now  = 1'b0;
        st_d     = st_q;
        unique case (st_q)
            CLR_IDLE: begin
                local_go = call_valid && (score <= thresh);
                post_en  = call_valid && (score > thresh);
                if (post_en) st_d = CLR_WAIT;
            end
            CLR_WAIT: begin
                back    = ack_in && (ent_status == ST_DONE);
                // a completion seen this cycle holds the timer off
                tmo_now = (tmr_q == '0) && !done_hit && !back;
                if (back || tmo_now) st_d = CLR_IDLE;
            end
            default: st_d = CLR_IDLE;
        endcase
    end

    assign clear_en = back || tmo_now;
    assign busy     = (st_q == CLR_WAIT);

    // State register and wait timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CLR_IDLE;
            tmr_q <= '0;
        end else begin
            st_q <= st_d;
            if (post_en)
                tmr_q <= timeout;
            else if (st_q == CLR_WAIT && tmr_q != '0)
                tmr_q <= tmr_q - 1'b1;
        end
    end

    // Registered pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_local  <= 1'b0;
            hop_return <= 1'b0;
            req_pulse  <= 1'b0;
        end else begin
            run_local  <= local_go || tmo_now;
            hop_return <= back;
            req_pulse  <= post_en;
        end
    end

endmodule

// File: rtl/hop_callee_fsm.sv
module hop_callee_fsm
    import hop_pkg::*;
#(
    parameter int CID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant,
    input  logic [CID_W-1:0] grant_entry,
    input  logic             exec_done,
    output logic             busy,
    output logic             fin,
    output logic [CID_W-1:0] cur_entry
);

    callee_st_e       st_q, st_d;
    logic [CID_W-1:0] ent_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CLE_IDLE: if (grant)     st_d = CLE_EXEC;
            CLE_EXEC: if (exec_done) st_d = CLE_IDLE;
            default:                 st_d = CLE_IDLE;
        endcase
    end

    // State register and held entry index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CLE_IDLE;
            ent_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == CLE_IDLE && grant) ent_q <= grant_entry;
        end
    end

    // Outputs
    always_comb begin
        busy      = (st_q == CLE_EXEC);
        fin       = (st_q == CLE_EXEC) && exec_done;
        cur_entry = ent_q;
    end

endmodule

// File: rtl/hop_claim_arb.sv
module hop_claim_arb #(
    parameter int N_CORES = 16,
    parameter int CID_W   = 4
) (
    input  logic [N_CORES-1:0] pend_vec,
    input  logic [N_CORES-1:0] elig_vec,
    output logic               claim,
    output logic [CID_W-1:0]   ent_sel,
    output logic [CID_W-1:0]   core_sel
);

    logic has_ent;
    logic has_core;

    // Lowest index wins on both sides
    always_comb begin
        has_ent  = 1'b0;
        has_core = 1'b0;
        ent_sel  = '0;
        core_sel = '0;
        for (int i = N_CORES - 1; i >= 0; i--) begin
            if (pend_vec[i]) begin
                has_ent = 1'b1;
                ent_sel = CID_W'(i);
            end
            if (elig_vec[i]) begin
                has_core = 1'b1;
                core_sel = CID_W'(i);
            end
        end
        claim = has_ent && has_core;
    end

endmodule

// File: rtl/hop_dispatch_ctrl.sv
module hop_dispatch_ctrl
    import hop_pkg::*;
#(
    parameter int N_CORES = 16,
    parameter int SCORE_W = 8,
    parameter int PROC_W  = 8,
    parameter int TMO_W   = 16,
    localparam int CID_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SCORE_W-1:0]         cfg_thresh,
    input  logic [TMO_W-1:0]           cfg_timeout,
    input  logic [N_CORES-1:0]         call_valid,
    input  logic [N_CORES*PROC_W-1:0]  call_proc,
    input  logic [N_CORES*SCORE_W-1:0] core_vuln,
    input  logic [N_CORES-1:0]         exec_done,
    output logic [N_CORES-1:0]         run_local,
    output logic [N_CORES-1:0]         hop_return,
    output logic [N_CORES-1:0]         req_vec,
    output logic [N_CORES-1:0]         ack_vec,
    output logic [N_CORES-1:0]         exec_start,
    output logic [PROC_W-1:0]          exec_proc,
    output logic [CID_W-1:0]           exec_caller
);

    // Migration table, one entry per calling core
    logic             ent_valid  [N_CORES];
    hop_stat_e        ent_stat   [N_CORES];
    logic [PROC_W-1:0] ent_proc  [N_CORES];
    logic [CID_W-1:0] ent_callee [N_CORES];

    logic [N_CORES-1:0] caller_post;
    logic [N_CORES-1:0] caller_clear;
    logic [N_CORES-1:0] caller_busy;
    logic [N_CORES-1:0] caller_tmo;
    logic [N_CORES-1:0] cle_busy;
    logic [N_CORES-1:0] cle_fin;
    logic [CID_W-1:0]   cle_entry [N_CORES];
    logic [N_CORES-1:0] done_hit;
    logic [N_CORES-1:0] pend_vec;
    logic [N_CORES-1:0] elig_vec;

    logic               arb_claim;
    logic [CID_W-1:0]   arb_ent;
    logic [CID_W-1:0]   arb_core;

    hop_claim_arb #(
        .N_CORES (N_CORES),
        .CID_W   (CID_W)
    ) u_arb (
        .pend_vec (pend_vec),
        .elig_vec (elig_vec),
        .claim    (arb_claim),
        .ent_sel  (arb_ent),
        .core_sel (arb_core)
    );

    for (genvar i = 0; i < N_CORES; i++) begin : g_core
        logic [SCORE_W-1:0] vuln_i;
        logic               grant_i;

        assign vuln_i  = core_vuln[i*SCORE_W +: SCORE_W];
        assign grant_i = arb_claim && (arb_core == CID_W'(i));

        hop_caller_fsm #(
            .SCORE_W (SCORE_W),
            .TMO_W   (TMO_W)
        ) u_caller (
            .clk        (clk),
            .rst_n      (rst_n),
            .call_valid (call_valid[i]),
            .score      (vuln_i),
            .thresh     (cfg_thresh),
            .timeout    (cfg_timeout),
            .ent_status (ent_stat[i]),
            .ack_in     (ack_vec[i]),
            .done_hit   (done_hit[i]),
            .post_en    (caller_post[i]),
            .clear_en   (caller_clear[i]),
            .busy       (caller_busy[i]),
            .tmo_now    (caller_tmo[i]),
            .run_local  (run_local[i]),
            .hop_return (hop_return[i]),
            .req_pulse  (req_vec[i])
        );

        hop_callee_fsm #(
            .CID_W (CID_W)
        ) u_callee (
            .clk         (clk),
            .rst_n       (rst_n),
            .grant       (grant_i),
            .grant_entry (arb_ent),
            .exec_done   (exec_done[i]),
            .busy        (cle_busy[i]),
            .fin         (cle_fin[i]),
            .cur_entry   (cle_entry[i])
        );

        // Completion counts only from the recorded claimer of a live entry
        assign done_hit[i] = ent_valid[i] && (ent_stat[i] == ST_RUN)
                          && cle_fin[ent_callee[i]]
                          && (cle_entry[ent_callee[i]] == CID_W'(i));

        // An expiring entry is withheld from the claim
        assign pend_vec[i] = ent_valid[i] && (ent_stat[i] == ST_PEND)
                          && !caller_tmo[i];

        // Callee re-check of the score on its own core
        assign elig_vec[i] = !caller_busy[i] && !cle_busy[i]
                          && !call_valid[i] && (vuln_i <= cfg_thresh);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_valid[i]  <= 1'b0;
                ent_stat[i]   <= ST_IDLE;
                ent_proc[i]   <= '0;
                ent_callee[i] <= '0;
            end else if (caller_post[i]) begin
                ent_valid[i]  <= 1'b1;
                ent_stat[i]   <= ST_PEND;
                ent_proc[i]   <= call_proc[i*PROC_W +: PROC_W];
                ent_callee[i] <= '0;
            end else if (caller_clear[i]) begin
                ent_valid[i]  <= 1'b0;
                ent_stat[i]   <= ST_IDLE;
            end else begin
                if (arb_claim && arb_ent == CID_W'(i)) begin
                    ent_stat[i]   <= ST_RUN;
                    ent_callee[i] <= arb_core;
                end
                if (done_hit[i]) ent_stat[i] <= ST_DONE;
            end
        end
    end

    // Broadcast start and acknowledgement registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_start  <= '0;
            exec_proc   <= '0;
            exec_caller <= '0;
            ack_vec     <= '0;
        end else begin
            exec_start  <= '0;
            exec_proc   <= '0;
            exec_caller <= '0;
            if (arb_claim) begin
                exec_start[arb_core] <= 1'b1;
                exec_proc            <= ent_proc[arb_ent];
                exec_caller          <= arb_ent;
            end
            ack_vec <= done_hit;
        end
    end

endmodule

// File: rtl/hop_dispatch_chk.sv
module hop_dispatch_chk #(
    parameter int N_CORES = 16,
    parameter int CID_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_CORES-1:0] run_local,
    input logic [N_CORES-1:0] hop_return,
    input logic [N_CORES-1:0] req_vec,
    input logic [N_CORES-1:0] ack_vec,
    input logic [N_CORES-1:0] exec_start,
    input logic [CID_W-1:0]   exec_caller
);

    // R4
    start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exec_start));

    // R4
    claim_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|exec_start) |-> !exec_start[exec_caller]);

    // R9
    local_vs_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_local & hop_return) == '0);

    // R3
    post_vs_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vec & run_local) == '0);

    // R7
    return_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hop_return & ~$past(ack_vec)) == '0);

endmodule

bind hop_dispatch_ctrl hop_dispatch_chk #(
    .N_CORES (N_CORES),
    .CID_W   (CID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_local   (run_local),
    .hop_return  (hop_return),
    .req_vec     (req_vec),
    .ack_vec     (ack_vec),
    .exec_start  (exec_start),
    .exec_caller (exec_caller)
);

// File: tb/hop_dispatch_ctrl_tb.sv
module hop_dispatch_ctrl_tb;

    localparam int N       = 16;
    localparam int SW      = 8;
    localparam int PW      = 8;
    localparam int TW      = 16;
    localparam int CW      = 4;
    localparam int CLK_PER = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [SW-1:0]   cfg_thresh = '0;
    logic [TW-1:0]   cfg_timeout = '0;
    logic [N-1:0]    call_valid = '0;
    logic [N*PW-1:0] call_proc = '0;
    logic [N*SW-1:0] core_vuln = '0;
    logic [N-1:0]    exec_done = '0;
    logic [N-1:0]    run_local, hop_return, req_vec, ack_vec, exec_start;
    logic [PW-1:0]   exec_proc;
    logic [CW-1:0]   exec_caller;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    hop_dispatch_ctrl #(.N_CORES(N), .SCORE_W(SW), .PROC_W(PW), .TMO_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh), .cfg_timeout(cfg_timeout),
        .call_valid(call_valid), .call_proc(call_proc), .core_vuln(core_vuln),
        .exec_done(exec_done), .run_local(run_local), .hop_return(hop_return),
        .req_vec(req_vec), .ack_vec(ack_vec), .exec_start(exec_start),
        .exec_proc(exec_proc), .exec_caller(exec_caller)
    );

    // ---------------- behavioural reference model ----------------
    int          m_cst [N];   // 0 idle, 1 waiting
    int          m_tmr [N];
    bit          m_ev  [N];
    int          m_es  [N];   // 0 idle, 1 pending, 2 running, 3 done
    int          m_ep  [N];
    int          m_ec  [N];
    bit          m_kst [N];
    int          m_kent[N];
    logic [N-1:0] m_run = '0, m_ret = '0, m_req = '0, m_ack = '0, m_xs = '0;
    int          m_xp = 0, m_xc = 0;

    function automatic int vul(int i);
        return int'(core_vuln[i*SW +: SW]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_cst[i] = 0; m_tmr[i] = 0; m_ev[i] = 0; m_es[i] = 0;
                m_ep[i] = 0; m_ec[i] = 0; m_kst[i] = 0; m_kent[i] = 0;
            end
            m_run = '0; m_ret = '0; m_req = '0; m_ack = '0; m_xs = '0;
            m_xp = 0; m_xc = 0;
        end else begin
            logic [N-1:0] dh, tn, rn, el, nl, nq;
            int e, k, th;
            th = int'(cfg_thresh);
            for (int i = 0; i < N; i++) begin
                rn[i] = (m_cst[i] == 1) && m_ack[i] && m_ev[i] && (m_es[i] == 3);
                dh[i] = 1'b0;
                for (int c = 0; c < N; c++)
                    if (m_kst[c] && exec_done[c] && m_kent[c] == i && m_ev[i]
                        && m_es[i] == 2 && m_ec[i] == c) dh[i] = 1'b1;
                tn[i] = (m_cst[i] == 1) && (m_tmr[i] == 0) && !dh[i] && !rn[i];
                el[i] = (m_cst[i] == 0) && !m_kst[i] && !call_valid[i] && (vul(i) <= th);
                nq[i] = (m_cst[i] == 0) && call_valid[i] && (vul(i) > th);
                nl[i] = ((m_cst[i] == 0) && call_valid[i] && (vul(i) <= th)) || tn[i];
            end
            e = -1; k = -1;
            for (int i = 0; i < N; i++) begin
                if (e < 0 && m_ev[i] && m_es[i] == 1 && !tn[i]) e = i;
                if (k < 0 && el[i]) k = i;
            end
            m_run = nl; m_ret = rn; m_req = nq; m_ack = dh;
            m_xs = '0; m_xp = 0; m_xc = 0;
            if (e >= 0 && k >= 0) begin
                m_xs[k] = 1'b1; m_xp = m_ep[e]; m_xc = e;
            end
            for (int c = 0; c < N; c++) begin
                if (m_kst[c] && exec_done[c]) m_kst[c] = 0;
                else if (!m_kst[c] && e >= 0 && k == c) begin m_kst[c] = 1; m_kent[c] = e; end
            end
            for (int i = 0; i < N; i++) begin
                if (nq[i]) begin
                    m_ev[i] = 1; m_es[i] = 1; m_ep[i] = int'(call_proc[i*PW +: PW]); m_ec[i] = 0;
                    m_cst[i] = 1; m_tmr[i] = int'(cfg_timeout);
                end else if (tn[i] || rn[i]) begin
                    m_ev[i] = 0; m_es[i] = 0; m_cst[i] = 0;
                end else begin
                    if (e == i && k >= 0) begin m_es[i] = 2; m_ec[i] = k; end
                    if (dh[i]) m_es[i] = 3;
                    if (m_cst[i] == 1 && m_tmr[i] > 0) m_tmr[i] = m_tmr[i] - 1;
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(run_local == m_run, "R2/R8", "run_local", run_local, m_run);
            chk(hop_return == m_ret, "R7/R9", "hop_return", hop_return, m_ret);
            chk(req_vec == m_req, "R3", "req_vec", req_vec, m_req);
            chk(ack_vec == m_ack, "R6", "ack_vec", ack_vec, m_ack);
            chk(exec_start == m_xs, "R4/R5/R10", "exec_start", exec_start, m_xs);
            chk(int'(exec_proc) == m_xp && int'(exec_caller) == m_xc, "R4",
                "exec_proc/caller", {exec_proc, exec_caller}, {m_xp[7:0], m_xc[3:0]});
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic all_vuln(int v);
        for (int i = 0; i < N; i++) core_vuln[i*SW +: SW] = SW'(v);
    endtask

    task automatic set_v(int i, int v);
        core_vuln[i*SW +: SW] = SW'(v);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_checks++; n_fail++;
        $display("[TB] FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        cfg_thresh  = 8'd100;
        cfg_timeout = 16'd20;
        all_vuln(10);
        step(3);
        // R1: outputs quiet under reset
        chk({run_local, hop_return, req_vec, ack_vec, exec_start} == '0 &&
            exec_proc == '0 && exec_caller == '0, "R1", "reset outputs",
            {run_local, hop_return, req_vec}, 0);
        rst_n = 1'b1;
        step(2);
        chk({run_local, hop_return, req_vec, ack_vec, exec_start} == '0, "R1",
            "post-reset outputs", {run_local, req_vec}, 0);

        // R2: score equal to threshold runs locally
        set_v(3, 100); call_valid[3] = 1'b1;
        step();
        call_valid = '0;
        chk(run_local == 16'h0008, "R2", "local at boundary", run_local, 16'h0008);
        chk(req_vec == '0, "R2", "no request", req_vec, 0);
        all_vuln(10); step(2);

        // R3 R4 R6 R7: successful migration from core 0 to core 1
        set_v(0, 200); call_valid[0] = 1'b1; call_proc[0 +: PW] = 8'h5A;
        step();
        call_valid = '0;
        chk(req_vec == 16'h0001, "R3", "request", req_vec, 1);
        step();
        chk(exec_start == 16'h0002, "R4", "claimer", exec_start, 2);
        chk(exec_proc == 8'h5A, "R4", "exec_proc", exec_proc, 8'h5A);
        chk(exec_caller == 4'd0, "R4", "exec_caller", exec_caller, 0);
        exec_done[1] = 1'b1;
        step();
        exec_done = '0;
        chk(ack_vec == 16'h0001, "R6", "ack", ack_vec, 1);
        step();
        chk(hop_return == 16'h0001, "R7", "return", hop_return, 1);
        step(2);

        // R5: core 1 fails its own re-check, core 2 claims
        set_v(0, 200); set_v(1, 150); call_valid[0] = 1'b1; call_proc[0 +: PW] = 8'h11;
        step();
        call_valid = '0;
        step();
        chk(exec_start == 16'h0004, "R5", "recheck skips core 1", exec_start, 4);
        exec_done[2] = 1'b1;
        step();
        exec_done = '0;
        step();
        chk(hop_return == 16'h0001, "R5", "return after recheck", hop_return, 1);
        all_vuln(10); step(2);

        // R8: nobody eligible, timeout 3 expires after 4 waiting cycles
        cfg_timeout = 16'd3;
        all_vuln(200);
        call_valid[0] = 1'b1;
        step();
        call_valid = '0;
        for (int c = 0; c < 3; c++) begin
            step();
            chk(run_local[0] == 1'b0, "R8", "no early expiry", run_local, 0);
        end
        step();
        chk(run_local == 16'h0001, "R8", "expiry local run", run_local, 1);
        all_vuln(10); step(2);

        // R8: expiry while running, late completion dropped
        set_v(0, 200); call_valid[0] = 1'b1;
        step();
        call_valid = '0;
        step();
        chk(exec_start == 16'h0002, "R8", "claim before expiry", exec_start, 2);
        step(3);
        chk(run_local == 16'h0001, "R8", "expiry while running", run_local, 1);
        exec_done[1] = 1'b1;
        step();
        exec_done = '0;
        chk(ack_vec == '0, "R8", "late completion ignored", ack_vec, 0);
        step(2);

        // R9: completion in the expiry cycle wins
        set_v(0, 200); call_valid[0] = 1'b1;
        step();
        call_valid = '0;
        step();
        chk(exec_start == 16'h0002, "R9", "claim", exec_start, 2);
        step(2);
        exec_done[1] = 1'b1;
        step();
        exec_done = '0;
        chk(run_local == '0, "R9", "no fallback", run_local, 0);
        chk(ack_vec == 16'h0001, "R9", "ack", ack_vec, 1);
        step();
        chk(hop_return == 16'h0001, "R9", "return", hop_return, 1);
        chk(run_local == '0, "R9", "still no fallback", run_local, 0);
        all_vuln(10); step(2);

        // R4 R10: two callers at once, one claim per cycle, busy cores skipped
        cfg_timeout = 16'd20;
        set_v(0, 200); set_v(1, 200);
        call_valid = 16'h0003; call_proc[0 +: PW] = 8'hA0; call_proc[PW +: PW] = 8'hA1;
        step();
        call_valid = '0;
        chk(req_vec == 16'h0003, "R3", "two requests", req_vec, 3);
        step();
        chk(exec_start == 16'h0004 && exec_caller == 4'd0, "R10", "first claim core 2",
            exec_start, 4);
        step();
        chk(exec_start == 16'h0008 && exec_caller == 4'd1, "R10", "second claim core 3",
            exec_start, 8);
        exec_done = 16'h000C;
        step();
        exec_done = '0;
        chk(ack_vec == 16'h0003, "R6", "both acks", ack_vec, 3);
        step();
        chk(hop_return == 16'h0003, "R7", "both return", hop_return, 3);
        all_vuln(10); step(3);

        // Random phase against the model (R2..R10)
        cfg_thresh  = 8'd128;
        cfg_timeout = 16'd6;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            for (int i = 0; i < N; i++) begin
                call_valid[i] = ($urandom % 16) == 0;
                call_proc[i*PW +: PW] = PW'($urandom);
                core_vuln[i*SW +: SW] = SW'($urandom);
                exec_done[i] = ($urandom % 4) == 0;
            end
            step();
        end
        call_valid = '0; exec_done = '0;
        step(40);
        finish_run();
    end

endmodule